// File: doc/BRIEF.md
# Dual-Enable Byte-Wide Static Memory Model

This block models a byte-wide static memory that sits behind four control pins: a select that is active low, a second select that is active high, an active-low write strobe and an active-low read strobe. The part answers only while both selects are asserted together. Each clock edge captures the pins. The captured pins then decide whether the addressed byte is stored, driven out, or neither. Whenever the part is not selected it reports a power-down status.

The data pins are split into an input vector, an output vector and a drive-enable. A single tri-state buffer at the chip edge can then build the bidirectional bus from them. The interface always carries seventeen address bits. The storage array holds 2^STORE_W bytes, so a build for simulation or a smaller array can drop the upper address bits, which then alias. A parameter sets the number of capture stages placed in front of the decode logic.

The array is not cleared by reset. A byte read back before it has been written is undefined.

Top module: `sram_dual_en`

## Requirements
- R1: While reset is held and on the first cycles after it, with the pins idle, `dout_en` is 0, `pwr_down` is 1 and `dout` is 0.
- R2: The part counts as selected only when `ce_lo_n` is 0 and `ce_hi` is 1. `pwr_down` is 1 in every other combination of the two selects and 0 when the part is selected.
- R3: When the part is selected and `we_n` is 0, the byte on `din` is stored at the addressed location. A later read of that location returns it.
- R4: When the part is selected, `oe_n` is 0 and `we_n` is 1, `dout_en` is 1 and `dout` carries the stored byte at the address.
- R5: `dout_en` is 0 whenever the part is deselected, whenever `oe_n` is 1, or whenever a write is taking place.
- R6: A write takes precedence over a read. With `we_n` 0 and `oe_n` 0 the byte is still stored and `dout_en` stays 0.
- R7: If either select is deasserted in a cycle where `we_n` is 0, nothing is stored and the addressed byte keeps its old value. A write lasts only for the cycles in which all three conditions hold.
- R8: `dout` is all zeros whenever `dout_en` is 0.
- R9: Address bits at positions STORE_W and above are ignored. Address a and address a + k*2^STORE_W refer to the same byte.
- R10: With IN_STAGES = 1, the outputs follow the pins captured at the previous rising clock edge. A change on the pins does not reach the outputs before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data from the bus for a write |
| ce_lo_n | input | 1 | Select, active low |
| ce_hi | input | 1 | Select, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| dout | output | DATA_W | Data to the bus, zero while not driving |
| dout_en | output | 1 | Drive enable for the bus buffer |
| pwr_down | output | 1 | Set while the part is deselected |

## Verification
The hardest case to reach from the ports is a write that one select cancels while the other select and the write strobe stay active. That write leaves no trace on any output, so it can only be seen by a later read. The bench handles this by preloading one byte with a known value before each test. It then applies one of all sixteen combinations of the four control pins with a marker byte on `din`, and reads the byte back. Each time, it compares the result with the value predicted from the selection rule.

// File: rtl/sram_dual_en_pkg.sv
package sram_dual_en_pkg;

   typedef struct packed {
      logic ce_lo_n;
      logic ce_hi;
      logic we_n;
      logic oe_n;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);
   localparam ctl_t CTL_IDLE = '{ce_lo_n: 1'b1, ce_hi: 1'b0, we_n: 1'b1, oe_n: 1'b1};

   typedef enum logic [1:0] {
      ACC_OFF   = 2'd0,
      ACC_IDLE  = 2'd1,
      ACC_READ  = 2'd2,
      ACC_WRITE = 2'd3
   } acc_t;

endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler
   import sram_dual_en_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output ctl_t              ctl_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int W = CTL_W + ADDR_W + DATA_W;
   localparam logic [W-1:0] RST_VAL = {CTL_IDLE, {(ADDR_W + DATA_W){1'b0}}};

   logic [W-1:0] pipe_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
      end else begin
         pipe_q[0] <= {ctl_i, addr_i, data_i};
         for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      end
   end

   assign {ctl_o, addr_o, data_o} = pipe_q[STAGES-1];
endmodule

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
   import sram_dual_en_pkg::*;
(
   input  ctl_t ctl_i,
   output acc_t acc_o
);
   logic selected;
   assign selected = !ctl_i.ce_lo_n && ctl_i.ce_hi;

   always_comb begin
      if (!selected)          acc_o = ACC_OFF;
      else if (!ctl_i.we_n)   acc_o = ACC_WRITE;
      else if (!ctl_i.oe_n)   acc_o = ACC_READ;
      else                    acc_o = ACC_IDLE;
   end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cell_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cell_q[idx] <= wdata;
   end

   assign rdata = cell_q[idx];
endmodule

// File: rtl/sram_dual_en.sv
module sram_dual_en
   import sram_dual_en_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int STORE_W   = 10,
   parameter int IN_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              ce_lo_n,
   input  logic              ce_hi,
   input  logic              we_n,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              pwr_down
);
   if (STORE_W < 1 || STORE_W > ADDR_W) begin : g_bad_store
      $error("STORE_W must lie between 1 and ADDR_W");
   end
   if (IN_STAGES < 1) begin : g_bad_stages
      $error("IN_STAGES must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   ctl_t              pins;
   ctl_t              ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] din_q;
   logic [STORE_W-1:0] idx;
   logic [DATA_W-1:0] rd_byte;
   acc_t              acc;

   assign pins = '{ce_lo_n: ce_lo_n, ce_hi: ce_hi, we_n: we_n, oe_n: oe_n};

   sram_pin_sampler #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .STAGES (IN_STAGES)
   ) u_sampler (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_i  (pins),
      .addr_i (addr),
      .data_i (din),
      .ctl_o  (ctl_q),
      .addr_o (addr_q),
      .data_o (din_q)
   );

   sram_ctl_decode u_decode (
      .ctl_i (ctl_q),
      .acc_o (acc)
   );

   if (STORE_W == ADDR_W) begin : g_full_map
      assign idx = addr_q;
   end else begin : g_alias_map
      logic unused_hi;
      assign idx       = addr_q[STORE_W-1:0];
      assign unused_hi = ^addr_q[ADDR_W-1:STORE_W];
   end

   sram_store #(
      .AW (STORE_W),
      .DW (DATA_W)
   ) u_store (
      .clk   (clk),
      .wr_en (acc == ACC_WRITE),
      .idx   (idx),
      .wdata (din_q),
      .rdata (rd_byte)
   );

   assign dout_en  = (acc == ACC_READ);
   assign dout     = dout_en ? rd_byte : '0;
   assign pwr_down = (acc == ACC_OFF);
endmodule

// File: rtl/sram_dual_en_chk.sv
module sram_dual_en_chk #(
   parameter int DATA_W    = 8,
   parameter int IN_STAGES = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_lo_n,
   input logic              ce_hi,
   input logic              we_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en,
   input logic              pwr_down
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> dout == '0);

   p_off_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> !dout_en);

   if (IN_STAGES == 1) begin : g_one_stage
      p_sel_pd_r2: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> pwr_down == !$past(!ce_lo_n && ce_hi));

      p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> dout_en == $past(!ce_lo_n && ce_hi && we_n && !oe_n));

      p_write_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(!we_n)) |-> !dout_en);

      p_oe_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(oe_n)) |-> !dout_en);
   end
endmodule

bind sram_dual_en sram_dual_en_chk #(
   .DATA_W    (DATA_W),
   .IN_STAGES (IN_STAGES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_lo_n  (ce_lo_n),
   .ce_hi    (ce_hi),
   .we_n     (we_n),
   .oe_n     (oe_n),
   .dout     (dout),
   .dout_en  (dout_en),
   .pwr_down (pwr_down)
);

// File: tb/sram_dual_en_tb.sv
module sram_dual_en_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 17;
   localparam int DW = 8;
   localparam int SW = 6;
   localparam int DEPTH = 1 << SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          ce_lo_n = 1'b1;
   logic          ce_hi = 1'b0;
   logic          we_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [DW-1:0] dout;
   logic          dout_en;
   logic          pwr_down;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_dual_en #(
      .ADDR_W    (AW),
      .DATA_W    (DW),
      .STORE_W   (SW),
      .IN_STAGES (1)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .din      (din),
      .ce_lo_n  (ce_lo_n),
      .ce_hi    (ce_hi),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .dout     (dout),
      .dout_en  (dout_en),
      .pwr_down (pwr_down)
   );

   function automatic logic [DW-1:0] pat(input int a);
      return DW'((a * 29 + 7) & 8'hFF);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive pins right after a falling edge; outputs are sampled at the next falling edge.
   task automatic step(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic cl, input logic ch, input logic w, input logic o);
      addr = a; din = d; ce_lo_n = cl; ce_hi = ch; we_n = w; oe_n = o;
      @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(dout_en == 1'b0 && pwr_down == 1'b1 && dout == '0, "R1 in reset",
          {dout_en, pwr_down, dout}, {2'b01, 8'h00});
      rst_n = 1'b1;
      @(negedge clk);
      chk(dout_en == 1'b0 && pwr_down == 1'b1 && dout == '0, "R1 after reset",
          {dout_en, pwr_down, dout}, {2'b01, 8'h00});

      // R3/R6 sweep: write every byte, half of them with oe_n low
      for (int a = 0; a < DEPTH; a++) begin
         step(AW'(a), pat(a), 1'b0, 1'b1, 1'b0, a[0]);
         chk(dout_en == 1'b0 && pwr_down == 1'b0, "R6 write floats bus",
             {dout_en, pwr_down}, 0);
      end

      // R4/R9 sweep: read back through aliased addresses
      for (int a = 0; a < DEPTH; a++) begin
         logic [AW-1:0] ra;
         ra = AW'(a) | (AW'((a * 5) % 2048) << SW);
         step(ra, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
         chk(dout_en == 1'b1, "R4 read drives", dout_en, 1);
         chk(dout == pat(a), "R3 R9 readback", dout, pat(a));
      end

      // R2/R5/R7/R8: all sixteen control combinations at one location
      for (int k = 0; k < 16; k++) begin
         logic cl, ch, w, o, sel, exp_en;
         logic [DW-1:0] mark, exp_byte;
         {cl, ch, w, o} = 4'(k);
         sel = !cl && ch;
         exp_en = sel && w && !o;
         mark = 8'hC0 | 8'(k);
         step(AW'(9), 8'h3C, 1'b0, 1'b1, 1'b0, 1'b1);
         step(AW'(9), mark, cl, ch, w, o);
         chk(pwr_down == !sel, "R2 power-down", pwr_down, !sel);
         chk(dout_en == exp_en, "R5 drive enable", dout_en, exp_en);
         chk(dout == (exp_en ? 8'h3C : 8'h00), "R8 bus data", dout, exp_en ? 8'h3C : 8'h00);
         exp_byte = (sel && !w) ? mark : 8'h3C;
         step(AW'(9), 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
         chk(dout == exp_byte, "R7 write only when fully enabled", dout, exp_byte);
      end

      // R10: one-cycle latency from pins to outputs
      step(AW'(3), 8'h00, 1'b1, 1'b1, 1'b1, 1'b0);
      addr = AW'(3); ce_lo_n = 1'b0; ce_hi = 1'b1; we_n = 1'b1; oe_n = 1'b0;
      #1;
      chk(dout_en == 1'b0 && pwr_down == 1'b1, "R10 before edge", {dout_en, pwr_down}, 1);
      @(negedge clk);
      chk(dout_en == 1'b1 && dout == pat(3), "R10 after edge", {dout_en, dout}, {1'b1, pat(3)});

      step(AW'(0), 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
      summary();
   end
endmodule